// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block holds the floating-point registers of a processor core. It has 32 entries by default, with one read port and one write port. Beside every entry it keeps a format tag. The tag records how the value was last written or first read: single, word, double, long or uninterpreted. A tag can also be marked unknown once the register's meaning is lost. When a read asks for a format that conflicts with the tag, the block returns a fixed quiet-NaN pattern for the requested format instead of the stored bits. The register is then poisoned until it is written again.

A mode input selects the register width. In 64-bit mode every entry holds a full 64-bit value. In 32-bit mode each entry holds only 32 bits, so a 64-bit value spans an even/odd pair of entries. A 64-bit access to an odd entry in that mode raises a reserved-instruction exception. Format codes the block does not define raise a separate fault. Read data, the exception and the fault are all registered and appear one cycle after the request.

Top module: `fpr_tagfile`

## Requirements
- R1: Reset sets every tag to uninterpreted and clears all data. It also drives rd_valid, rd_data, exc_ri and fmt_fault to zero. A cycle with no request leaves exc_ri and fmt_fault low.
- R2: A read with rd_en high shows its result on rd_data, with rd_valid high, in the cycle after the request. Without a read, rd_valid is low and rd_data holds its last value.
- R3: Format codes are 0 uninterpreted, 1 single, 2 word, 3 double and 4 long. Code 5 is a write-only uninterpreted 32-bit store. mode64=1 selects 64-bit registers. Reading an uninterpreted-tagged register with a concrete format adopts that format as its tag and returns the stored bits.
- R4: A read whose format differs from the register's tag sets the tag to unknown. Such a read, and any concrete read of an unknown register, returns the quiet NaN of the requested format: single 0x7FBFFFFF, word 0x7FFFFFFF, double 0x7FF7FFFFFFFFFFFF, long 0x7FFFFFFFFFFFFFFF.
- R5: A read with format 0 uses the register's current tag as its format. If that tag is unknown, the read raises fmt_fault and returns zero.
- R6: Single and word reads return the low 32 bits of the register, zero-extended to 64 bits.
- R7: In 64-bit mode, a single, word or code-5 write stores the low 32 data bits and fills the upper 32 bits with 0xDEADC0DE. Code 5 leaves the tag uninterpreted. A double, long or code-0 write stores all 64 bits.
- R8: In 32-bit mode, a 64-bit-format write to even entry n puts the low half in n and the high half in n+1, and tags both entries. A 64-bit read of even n returns entry n+1 as bits 63:32 and entry n as bits 31:0.
- R9: In 32-bit mode, a 64-bit-format access (codes 0, 3, 4) to an odd entry raises exc_ri one cycle later. Such a read returns zero and leaves the tag unchanged. Such a write stores nothing and sets the tags of n and n+1 to unknown.
- R10: An undefined format raises fmt_fault one cycle later, leaves the data unchanged and sets the target entry's tag to unknown. Codes 5 to 7 are undefined on reads; codes 6 and 7 are undefined on writes.
- R11: When a read and a write address the same entry in one cycle, the read sees the old data and the old tag. The write's tag update takes precedence over any tag change the read would make.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 = 64-bit registers, 0 = 32-bit registers with pairing |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Read entry number |
| rd_fmt | input | 3 | Read format code |
| rd_valid | output | 1 | Read result valid (one cycle after rd_en) |
| rd_data | output | 64 | Read result |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write entry number |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write data |
| exc_ri | output | 1 | Reserved-instruction exception (odd 64-bit access in 32-bit mode) |
| fmt_fault | output | 1 | Undefined format, or uninterpreted read of an unknown register |

## Verification
A tag update can come from the read port and from the write port in the same cycle. That is the overlap under test. The bench provokes it by issuing a read and a write to one entry together, in two cases. In the first, the read conflicts with the old tag and would poison the entry. In the second, the entry is still uninterpreted and the read would adopt a format. In each case the read result is compared with the value the old tag implies. A later read in the written format must then return the written bits unpoisoned, which shows that the write's tag prevailed.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int HALF_W = 32;
  localparam int FULL_W = 2 * HALF_W;
  localparam int FMT_W  = 3;

  // request format codes
  localparam logic [FMT_W-1:0] FMT_RAW   = 3'd0;
  localparam logic [FMT_W-1:0] FMT_SGL   = 3'd1;
  localparam logic [FMT_W-1:0] FMT_WRD   = 3'd2;
  localparam logic [FMT_W-1:0] FMT_DBL   = 3'd3;
  localparam logic [FMT_W-1:0] FMT_LNG   = 3'd4;
  localparam logic [FMT_W-1:0] FMT_RAW32 = 3'd5;

  // stored tag values (concrete ones match the request codes)
  localparam logic [FMT_W-1:0] TAG_RAW = 3'd0;
  localparam logic [FMT_W-1:0] TAG_UNK = 3'd5;

  localparam logic [HALF_W-1:0] HI_FILL = 32'hDEADC0DE;

  function automatic logic is_wide(input logic [FMT_W-1:0] f);
    return (f == FMT_RAW) || (f == FMT_DBL) || (f == FMT_LNG);
  endfunction

  function automatic logic [FULL_W-1:0] qnan_of(input logic [FMT_W-1:0] f);
    case (f)
      FMT_SGL: qnan_of = 64'h0000_0000_7FBF_FFFF;
      FMT_WRD: qnan_of = 64'h0000_0000_7FFF_FFFF;
      FMT_DBL: qnan_of = 64'h7FF7_FFFF_FFFF_FFFF;
      FMT_LNG: qnan_of = 64'h7FFF_FFFF_FFFF_FFFF;
      default: qnan_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/fpr_rd_view.sv
module fpr_rd_view
  import fpr_pkg::*;
(
  input  logic              mode64,
  input  logic [FMT_W-1:0]  fmt,
  input  logic              odd,
  input  logic [FMT_W-1:0]  tag,
  input  logic [HALF_W-1:0] lo,
  input  logic [HALF_W-1:0] lo_pair,
  input  logic [HALF_W-1:0] hi,
  output logic [FULL_W-1:0] data,
  output logic              exc,
  output logic              fault,
  output logic              tag_we,
  output logic [FMT_W-1:0]  tag_nx
);
  logic [FMT_W-1:0] eff;
  logic             wide;
  logic             poison;

  always_comb begin
    data   = '0;
    exc    = 1'b0;
    fault  = 1'b0;
    tag_we = 1'b0;
    tag_nx = tag;
    poison = 1'b0;
    eff    = (fmt == FMT_RAW) ? tag : fmt;
    wide   = is_wide(eff);
    if (fmt > FMT_LNG) begin
      fault  = 1'b1;
      tag_we = 1'b1;
      tag_nx = TAG_UNK;
    end else if (eff == TAG_UNK) begin
      fault = 1'b1;
    end else if (!mode64 && wide && odd) begin
      exc = 1'b1;
    end else begin
      if (tag == TAG_RAW) begin
        if (eff != TAG_RAW) begin
          tag_we = 1'b1;
          tag_nx = eff;
        end
      end else if (eff != tag) begin
        poison = 1'b1;
        tag_we = 1'b1;
        tag_nx = TAG_UNK;
      end
      if (poison)      data = qnan_of(eff);
      else if (!wide)  data = {{HALF_W{1'b0}}, lo};
      else if (mode64) data = {hi, lo};
      else             data = {lo_pair, lo};
    end
  end
endmodule

// File: rtl/fpr_wr_plan.sv
module fpr_wr_plan
  import fpr_pkg::*;
(
  input  logic              mode64,
  input  logic [FMT_W-1:0]  fmt,
  input  logic              odd,
  input  logic [FULL_W-1:0] data,
  output logic              lo_we,
  output logic [HALF_W-1:0] lo_val,
  output logic              hi_we,
  output logic [HALF_W-1:0] hi_val,
  output logic              pair_we,
  output logic [HALF_W-1:0] pair_val,
  output logic              tag_we,
  output logic [FMT_W-1:0]  tag_nx,
  output logic              tag2_we,
  output logic [FMT_W-1:0]  tag2_nx,
  output logic              exc,
  output logic              fault
);
  logic             narrow;
  logic [FMT_W-1:0] ftag;

  always_comb begin
    lo_we    = 1'b0;
    hi_we    = 1'b0;
    pair_we  = 1'b0;
    tag_we   = 1'b0;
    tag2_we  = 1'b0;
    exc      = 1'b0;
    fault    = 1'b0;
    tag_nx   = TAG_UNK;
    tag2_nx  = TAG_UNK;
    lo_val   = data[HALF_W-1:0];
    pair_val = data[FULL_W-1:HALF_W];
    hi_val   = data[FULL_W-1:HALF_W];
    narrow   = (fmt == FMT_SGL) || (fmt == FMT_WRD) || (fmt == FMT_RAW32);
    ftag     = (fmt == FMT_RAW32) ? TAG_RAW : fmt;
    if (fmt > FMT_RAW32) begin
      fault  = 1'b1;
      tag_we = 1'b1;
    end else if (mode64) begin
      lo_we  = 1'b1;
      hi_we  = 1'b1;
      hi_val = narrow ? HI_FILL : data[FULL_W-1:HALF_W];
      tag_we = 1'b1;
      tag_nx = ftag;
    end else if (narrow) begin
      lo_we  = 1'b1;
      tag_we = 1'b1;
      tag_nx = ftag;
    end else if (!odd) begin
      lo_we   = 1'b1;
      pair_we = 1'b1;
      tag_we  = 1'b1;
      tag_nx  = ftag;
      tag2_we = 1'b1;
      tag2_nx = ftag;
    end else begin
      exc     = 1'b1;
      tag_we  = 1'b1;
      tag2_we = 1'b1;
    end
  end
endmodule

// File: rtl/fpr_tagfile.sv
module fpr_tagfile
  import fpr_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode64,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_idx,
  input  logic [FMT_W-1:0]  rd_fmt,
  output logic              rd_valid,
  output logic [FULL_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [FMT_W-1:0]  wr_fmt,
  input  logic [FULL_W-1:0] wr_data,
  output logic              exc_ri,
  output logic              fmt_fault
);
  logic [HALF_W-1:0] lo_q  [NREG];
  logic [HALF_W-1:0] hi_q  [NREG];
  logic [FMT_W-1:0]  tag_q [NREG];

  logic [AW-1:0]     rd_pidx;
  logic [AW:0]       wr_nxt;
  logic [NREG-1:0]   w_hit, w2_hit, r_hit;

  logic [FULL_W-1:0] r_data;
  logic              r_exc, r_fault, r_tag_we;
  logic [FMT_W-1:0]  r_tag;

  logic              w_lo_we, w_hi_we, w_pair_we, w_tag_we, w_tag2_we, w_exc, w_fault;
  logic [HALF_W-1:0] w_lo, w_hi, w_pair;
  logic [FMT_W-1:0]  w_tag, w_tag2;

  assign rd_pidx = {rd_idx[AW-1:1], 1'b1};
  assign wr_nxt  = {1'b0, wr_idx} + 1'b1;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_hit
    assign w_hit[gi]  = wr_en && (wr_idx == AW'(gi));
    assign w2_hit[gi] = wr_en && (wr_nxt == (AW+1)'(gi));
    assign r_hit[gi]  = rd_en && (rd_idx == AW'(gi));
  end

  fpr_rd_view i_rd (
    .mode64 (mode64),
    .fmt    (rd_fmt),
    .odd    (rd_idx[0]),
    .tag    (tag_q[rd_idx]),
    .lo     (lo_q[rd_idx]),
    .lo_pair(lo_q[rd_pidx]),
    .hi     (hi_q[rd_idx]),
    .data   (r_data),
    .exc    (r_exc),
    .fault  (r_fault),
    .tag_we (r_tag_we),
    .tag_nx (r_tag)
  );

  fpr_wr_plan i_wr (
    .mode64  (mode64),
    .fmt     (wr_fmt),
    .odd     (wr_idx[0]),
    .data    (wr_data),
    .lo_we   (w_lo_we),
    .lo_val  (w_lo),
    .hi_we   (w_hi_we),
    .hi_val  (w_hi),
    .pair_we (w_pair_we),
    .pair_val(w_pair),
    .tag_we  (w_tag_we),
    .tag_nx  (w_tag),
    .tag2_we (w_tag2_we),
    .tag2_nx (w_tag2),
    .exc     (w_exc),
    .fault   (w_fault)
  );

  // storage and tags: write port wins over read-side tag updates
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        tag_q[i] <= TAG_RAW;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (w_hit[i] && w_tag_we)        tag_q[i] <= w_tag;
        else if (w2_hit[i] && w_tag2_we) tag_q[i] <= w_tag2;
        else if (r_hit[i] && r_tag_we)   tag_q[i] <= r_tag;
        if (w_hit[i] && w_lo_we)         lo_q[i]  <= w_lo;
        else if (w2_hit[i] && w_pair_we) lo_q[i]  <= w_pair;
        if (w_hit[i] && w_hi_we)         hi_q[i]  <= w_hi;
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      exc_ri    <= 1'b0;
      fmt_fault <= 1'b0;
    end else begin
      rd_valid  <= rd_en;
      if (rd_en) rd_data <= r_data;
      exc_ri    <= (rd_en && r_exc) || (wr_en && w_exc);
      fmt_fault <= (rd_en && r_fault) || (wr_en && w_fault);
    end
  end
endmodule

// File: rtl/fpr_tagfile_chk.sv
module fpr_tagfile_chk
  import fpr_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int AW   = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst,
  input logic              mode64,
  input logic              rd_en,
  input logic [AW-1:0]     rd_idx,
  input logic [FMT_W-1:0]  rd_fmt,
  input logic              rd_valid,
  input logic [FULL_W-1:0] rd_data,
  input logic              wr_en,
  input logic [AW-1:0]     wr_idx,
  input logic [FMT_W-1:0]  wr_fmt,
  input logic              exc_ri,
  input logic              fmt_fault
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |=> (!exc_ri && !fmt_fault));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_fmt == FMT_SGL || rd_fmt == FMT_WRD)) |=> (rd_data[FULL_W-1:HALF_W] == '0));

  a_r9_odd_read_exc: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mode64 && rd_idx[0] && (rd_fmt == FMT_DBL || rd_fmt == FMT_LNG)) |=> exc_ri);

  a_r9_odd_write_exc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode64 && wr_idx[0] &&
     (wr_fmt == FMT_RAW || wr_fmt == FMT_DBL || wr_fmt == FMT_LNG)) |=> exc_ri);

  a_r10_bad_write_fault: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_fmt > FMT_RAW32) |=> fmt_fault);

  a_r10_bad_read_fault: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_fmt > FMT_LNG) |=> (fmt_fault && rd_data == '0));
endmodule

bind fpr_tagfile fpr_tagfile_chk #(.NREG(NREG)) i_chk (
  .clk(clk), .rst(rst), .mode64(mode64),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt),
  .exc_ri(exc_ri), .fmt_fault(fmt_fault)
);

// File: tb/test_fpr_tagfile.sv
module test_fpr_tagfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode64 = 1'b1;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_idx = '0;
  logic [2:0]  rd_fmt = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [2:0]  wr_fmt = '0;
  logic [63:0] wr_data = '0;
  logic        exc_ri, fmt_fault;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [63:0] QS = 64'h0000_0000_7FBF_FFFF;
  localparam logic [63:0] QW = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] QD = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam logic [63:0] QL = 64'h7FFF_FFFF_FFFF_FFFF;

  always #10 clk = ~clk;

  fpr_tagfile i_fpr_tagfile (
    .clk(clk), .rst(rst), .mode64(mode64),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data),
    .exc_ri(exc_ri), .fmt_fault(fmt_fault)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] idx, input logic [2:0] f);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx; rd_fmt = f;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [2:0] f, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_fmt = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic both(input logic [4:0] idx, input logic [2:0] rf,
                      input logic [2:0] wf, input logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx; rd_fmt = rf;
    wr_en = 1'b1; wr_idx = idx; wr_fmt = wf; wr_data = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
    chk("R1 rd_data after reset", rd_data, 64'd0);
    chk("R1 exc_ri after reset", 64'(exc_ri), 64'd0);
    chk("R1 fmt_fault after reset", 64'(fmt_fault), 64'd0);
    rd(5'd10, 3'd1);
    chk("R1 fresh entry read raw, no poison", rd_data, 64'd0);
  endtask

  task automatic t_tags;
    rd(5'd10, 3'd1);
    chk("R3 adopted single reads raw", rd_data, 64'd0);
    rd(5'd10, 3'd2);
    chk("R4 word read of single -> word qnan", rd_data, QW);
    rd(5'd10, 3'd1);
    chk("R4 unknown entry single read", rd_data, QS);
    rd(5'd10, 3'd3);
    chk("R4 unknown entry double read", rd_data, QD);
    rd(5'd10, 3'd4);
    chk("R4 unknown entry long read", rd_data, QL);
  endtask

  task automatic t_wide64;
    mode64 = 1'b1;
    wr(5'd2, 3'd1, 64'h1111_2222_3F80_0000);
    rd(5'd2, 3'd1);
    chk("R6 single read zero-extended", rd_data, 64'h0000_0000_3F80_0000);
    wr(5'd3, 3'd5, 64'hAAAA_BBBB_1234_5678);
    rd(5'd3, 3'd0);
    chk("R7 narrow write upper fill", rd_data, 64'hDEAD_C0DE_1234_5678);
    wr(5'd4, 3'd3, 64'h4000_0000_0000_0001);
    rd(5'd4, 3'd0);
    chk("R5 format-0 read uses double tag", rd_data, 64'h4000_0000_0000_0001);
    rd(5'd4, 3'd4);
    chk("R4 long read of double -> long qnan", rd_data, QL);
  endtask

  task automatic t_pair32;
    mode64 = 1'b0;
    wr(5'd6, 3'd4, 64'h0123_4567_89AB_CDEF);
    rd(5'd6, 3'd4);
    chk("R8 paired long read back", rd_data, 64'h0123_4567_89AB_CDEF);
    chk("R8 no exception on even pair", 64'(exc_ri), 64'd0);
    wr(5'd8, 3'd5, 64'h0000_0000_CAFE_F00D);
    wr(5'd9, 3'd5, 64'h0000_0000_1357_9BDF);
    rd(5'd8, 3'd3);
    chk("R8 double read joins n+1:n", rd_data, 64'h1357_9BDF_CAFE_F00D);
  endtask

  task automatic t_odd32;
    mode64 = 1'b0;
    rd(5'd7, 3'd3);
    chk("R9 odd double read raises exc", 64'(exc_ri), 64'd1);
    chk("R9 odd double read data zero", rd_data, 64'd0);
    mode64 = 1'b1;
    rd(5'd7, 3'd4);
    chk("R9 odd read left long tag intact", rd_data, 64'h0000_0000_0123_4567);
    mode64 = 1'b0;
    wr(5'd11, 3'd3, 64'h3FF0_0000_0000_0000);
    chk("R9 odd double write raises exc", 64'(exc_ri), 64'd1);
    rd(5'd11, 3'd1);
    chk("R9 odd write marks n unknown", rd_data, QS);
    rd(5'd12, 3'd2);
    chk("R9 odd write marks n+1 unknown", rd_data, QW);
  endtask

  task automatic t_fault;
    wr(5'd13, 3'd7, 64'h5);
    chk("R10 bad write format faults", 64'(fmt_fault), 64'd1);
    chk("R10 bad write format no exc", 64'(exc_ri), 64'd0);
    rd(5'd13, 3'd2);
    chk("R10 bad write left tag unknown", rd_data, QW);
    rd(5'd14, 3'd6);
    chk("R10 bad read format faults", 64'(fmt_fault), 64'd1);
    chk("R10 bad read format data zero", rd_data, 64'd0);
    rd(5'd14, 3'd1);
    chk("R10 bad read left tag unknown", rd_data, QS);
    rd(5'd13, 3'd0);
    chk("R5 format-0 read of unknown faults", 64'(fmt_fault), 64'd1);
    chk("R5 format-0 read of unknown data zero", rd_data, 64'd0);
  endtask

  task automatic t_collide;
    mode64 = 1'b1;
    wr(5'd20, 3'd2, 64'h11);
    both(5'd20, 3'd1, 3'd3, 64'hD0D0_0000_0000_0005);
    chk("R11 read sees old word tag -> single qnan", rd_data, QS);
    rd(5'd20, 3'd3);
    chk("R11 write tag beats read poison", rd_data, 64'hD0D0_0000_0000_0005);
    both(5'd21, 3'd1, 3'd4, 64'h77);
    chk("R11 read sees old data", rd_data, 64'd0);
    rd(5'd21, 3'd4);
    chk("R11 write tag beats read adoption", rd_data, 64'h77);
  endtask

  task automatic t_hold;
    logic [63:0] last;
    rd(5'd2, 3'd1);
    chk("R2 rd_valid after read", 64'(rd_valid), 64'd1);
    last = rd_data;
    @(negedge clk);
    @(negedge clk);
    chk("R2 rd_valid low when idle", 64'(rd_valid), 64'd0);
    chk("R2 rd_data held when idle", rd_data, last);
    chk("R1 idle leaves exc and fault low", 64'({exc_ri, fmt_fault}), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tags();
    t_wide64();
    t_pair32();
    t_odd32();
    t_fault();
    t_collide();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule